// File: doc/BRIEF.md
# Burst Dimming PWM Generator

This block produces the low-frequency burst signal that gates a lamp inverter for brightness control. While the burst output is high the lamp drive runs. While it is low the drive is held off. The burst comes from one of two sources. In internal mode, a free-running period counter is compared against an 8-bit brightness code, and a slope-select input can invert the brightness response. In external mode, an asynchronous PWM input is synchronised and passed through. The period register sets the burst frequency, so a system clock of a few MHz with a suitable period value gives the 80 Hz to 300 Hz range used for dimming.

The block also produces a soft-start ramp value that limits the lamp current reference. The ramp starts from zero at the beginning of every burst. It climbs by one step every `RAMP_DIV` clocks and stops at full scale. It is forced to zero while the burst is off.

Top module: `burst_dim_gen`

## Requirements
- R1: While `rst_n` is low and on the first clock after release, `burst_o` is 0 and `ramp_o` is 0.
- R2: In internal mode, one burst cycle lasts P+1 clocks, where P is the period value sampled at the end of the previous cycle. After reset, the first cycle samples `period_i` at once.
- R3: The effective duty code is taken only on the last clock of a cycle. A brightness change inside a cycle does not alter that cycle's burst.
- R4: In internal mode, with counter value c (running 0..P) and effective duty D, `burst_o` one clock later is 1 exactly when c*256 < D*(P+1). D = 0 never raises the burst.
- R5: With `slope_inv_i` = 0, D equals `bright_i`. With `slope_inv_i` = 1, D equals 255 - `bright_i`.
- R6: With `ext_mode_i` = 1, `burst_o` equals `pwm_ext_i` delayed by three clocks: two synchroniser flops and the output register. `bright_i` and `slope_inv_i` have no effect on it.
- R7: If `burst_o` is 0 on some clock, `ramp_o` is 0 on the next clock.
- R8: While the burst stays high and no new burst starts, `ramp_o` rises by exactly 1 every `RAMP_DIV` clocks. It holds at 255 once it gets there.
- R9: A burst start clears the ramp to 0 and restarts its step timer. In external mode a burst start is a rising edge of the synchronised input. In internal mode it is the first clock of every cycle, even when the burst stays high across the cycle boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ext_mode_i | input | 1 | 0: internal PWM, 1: external PWM pass-through |
| slope_inv_i | input | 1 | 0: positive brightness slope, 1: inverted |
| bright_i | input | 8 | Brightness code |
| period_i | input | CNT_W | Burst period minus one, in clocks |
| pwm_ext_i | input | 1 | Asynchronous external dimming PWM |
| burst_o | output | 1 | Burst gate for the lamp drive |
| ramp_o | output | 8 | Soft-start current limit value |

## Verification
Two events can land on the same clock: a period boundary, where a new duty code is loaded, and a soft-start step or restart. The clash is provoked with full brightness on a short period. Here the burst never drops, so only the boundary restart can return the ramp to zero. The step timer is still running when that restart arrives, so the restart competes with a pending ramp step. A cycle-accurate bench model, built from the requirements, judges every clock of that stretch, as well as the random brightness changes made in the middle of a period.

// File: rtl/bdg_pkg.sv
package bdg_pkg;
  typedef enum logic { SRC_INT = 1'b0, SRC_EXT = 1'b1 } burst_src_e;

  function automatic logic [7:0] apply_slope(input logic [7:0] code, input logic inv);
    return inv ? ~code : code;
  endfunction
endpackage

// File: rtl/bdg_period_ctr.sv
module bdg_period_ctr #(
  parameter int CNT_W  = 16,
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  period_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  per_o,
  output logic [DUTY_W-1:0] duty_o
);
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  per_q, per_d;
  logic [DUTY_W-1:0] duty_q, duty_d;
  logic              wrap;

  always_comb begin
    wrap   = (cnt_q == per_q);
    cnt_d  = cnt_q + CNT_W'(1);
    per_d  = per_q;
    duty_d = duty_q;
    if (wrap) begin
      cnt_d  = '0;
      per_d  = period_i;
      duty_d = duty_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      per_q  <= '0;
      duty_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      per_q  <= per_d;
      duty_q <= duty_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign per_o  = per_q;
  assign duty_o = duty_q;

  // R2: the counter never passes the captured period
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= per_q);

  // R3: duty only changes across a boundary
  p_duty_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != per_q) |=> $stable(duty_q));
endmodule

// File: rtl/bdg_sync.sv
module bdg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign sync_o = sh_q[STAGES-1];
endmodule

// File: rtl/bdg_softstart.sv
module bdg_softstart #(
  parameter int RAMP_W   = 8,
  parameter int RAMP_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burst_i,
  input  logic              start_i,
  output logic [RAMP_W-1:0] ramp_o
);
  localparam int DIV_W = (RAMP_DIV > 1) ? $clog2(RAMP_DIV) : 1;
  localparam logic [DIV_W-1:0]  DIV_LAST = DIV_W'(RAMP_DIV - 1);
  localparam logic [RAMP_W-1:0] RAMP_MAX = '1;

  logic [DIV_W-1:0]  div_q, div_d;
  logic [RAMP_W-1:0] ramp_q, ramp_d;
  logic              step_en;

  always_comb begin
    step_en = (div_q == DIV_LAST);
    div_d   = div_q;
    ramp_d  = ramp_q;
    if (!burst_i || start_i) begin
      div_d  = '0;
      ramp_d = '0;
    end else if (step_en) begin
      div_d = '0;
      if (ramp_q != RAMP_MAX) ramp_d = ramp_q + RAMP_W'(1);
    end else begin
      div_d = div_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      ramp_q <= '0;
    end else begin
      div_q  <= div_d;
      ramp_q <= ramp_d;
    end
  end

  assign ramp_o = ramp_q;

  // R7: burst off forces the ramp to zero
  p_zero_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_i |=> (ramp_o == '0));

  // R8: ramp moves by at most one step while a burst continues
  p_step_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_i && !start_i) |=> (ramp_o == $past(ramp_o)) || (ramp_o == $past(ramp_o) + RAMP_W'(1)));

  // R8: saturation holds
  p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_i && !start_i && ramp_o == RAMP_MAX) |=> (ramp_o == RAMP_MAX));

  // R9: burst start clears the ramp
  p_start_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (ramp_o == '0));
endmodule

// File: rtl/burst_dim_gen.sv
module burst_dim_gen #(
  parameter int CNT_W    = 16,
  parameter int RAMP_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_mode_i,
  input  logic             slope_inv_i,
  input  logic [7:0]       bright_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             pwm_ext_i,
  output logic             burst_o,
  output logic [7:0]       ramp_o
);
  import bdg_pkg::*;

  localparam int DUTY_W = 8;
  localparam int PW     = CNT_W + DUTY_W + 1;

  burst_src_e        src;
  logic [DUTY_W-1:0] duty_eff, duty_q;
  logic [CNT_W-1:0]  cnt_q, per_q;
  logic              ext_sync;
  logic [PW-1:0]     lhs, rhs;
  logic              burst_int;
  logic              burst_q, burst_d;
  logic              start_q, start_d;

  assign src      = burst_src_e'(ext_mode_i);
  assign duty_eff = apply_slope(bright_i, slope_inv_i);

  bdg_period_ctr #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .duty_i(duty_eff),
    .cnt_o(cnt_q), .per_o(per_q), .duty_o(duty_q)
  );

  bdg_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pwm_ext_i), .sync_o(ext_sync)
  );

  always_comb begin
    lhs       = PW'({cnt_q, {DUTY_W{1'b0}}});
    rhs       = PW'(duty_q) * (PW'(per_q) + PW'(1));
    burst_int = (lhs < rhs);
    if (src == SRC_EXT) begin
      burst_d = ext_sync;
      start_d = ext_sync & ~burst_q;
    end else begin
      burst_d = burst_int;
      start_d = (cnt_q == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_q <= 1'b0;
      start_q <= 1'b0;
    end else begin
      burst_q <= burst_d;
      start_q <= start_d;
    end
  end

  bdg_softstart #(.RAMP_W(8), .RAMP_DIV(RAMP_DIV)) u_ramp (
    .clk(clk), .rst_n(rst_n), .burst_i(burst_q), .start_i(start_q), .ramp_o(ramp_o)
  );

  assign burst_o = burst_q;

  // R6: external mode output follows the synchroniser
  p_ext_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mode_i |=> (burst_o == $past(ext_sync)));

  // R4: zero duty never raises the internal burst
  p_zero_duty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode_i && duty_q == '0) |=> !burst_o);
endmodule

// File: tb/sim_burst_dim_gen.sv
module sim_burst_dim_gen;
  localparam int CNT_W = 16;
  localparam int RDIV  = 3;

  logic             clk, rst_n, ext_mode_i, slope_inv_i, pwm_ext_i;
  logic [7:0]       bright_i;
  logic [CNT_W-1:0] period_i;
  logic             burst_o;
  logic [7:0]       ramp_o;

  int    checks = 0;
  int    errors = 0;
  string phase_tag = "R1";

  burst_dim_gen #(.CNT_W(CNT_W), .RAMP_DIV(RDIV)) u0 (
    .clk(clk), .rst_n(rst_n), .ext_mode_i(ext_mode_i), .slope_inv_i(slope_inv_i),
    .bright_i(bright_i), .period_i(period_i), .pwm_ext_i(pwm_ext_i),
    .burst_o(burst_o), .ramp_o(ramp_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // reference model from the requirements
  int   m_cnt, m_per, m_duty, m_div, m_ramp;
  logic m_s1, m_s2, m_burst, m_start;

  function automatic logic int_burst(int c, int p, int d);
    return (longint'(c) * 256) < (longint'(d) * (longint'(p) + 1));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_per <= 0; m_duty <= 0; m_div <= 0; m_ramp <= 0;
      m_s1 <= 0; m_s2 <= 0; m_burst <= 0; m_start <= 0;
    end else begin
      if (m_cnt == m_per) begin
        m_cnt  <= 0;
        m_per  <= int'(period_i);
        m_duty <= slope_inv_i ? 255 - int'(bright_i) : int'(bright_i);
      end else m_cnt <= m_cnt + 1;
      m_s1 <= pwm_ext_i;
      m_s2 <= m_s1;
      m_burst <= ext_mode_i ? m_s2 : int_burst(m_cnt, m_per, m_duty);
      m_start <= ext_mode_i ? (m_s2 && !m_burst) : (m_cnt == 0);
      if (!m_burst || m_start) begin
        m_div <= 0; m_ramp <= 0;
      end else if (m_div == RDIV - 1) begin
        m_div <= 0;
        if (m_ramp < 255) m_ramp <= m_ramp + 1;
      end else m_div <= m_div + 1;
    end
  end

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(phase_tag, int'(burst_o), int'(m_burst), "burst");
      check(!m_burst ? "R7" : (m_start ? "R9" : "R8"), int'(ramp_o), m_ramp, "ramp");
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_200_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hi_cnt;
    int t_gap;
    void'($urandom(32'd1234));
    rst_n = 0; ext_mode_i = 0; slope_inv_i = 0; bright_i = 8'd128;
    period_i = 16'd9; pwm_ext_i = 0;
    repeat (3) @(negedge clk);
    check("R1", int'(burst_o), 0, "burst in reset");
    check("R1", int'(ramp_o), 0, "ramp in reset");
    rst_n = 1;
    @(negedge clk);
    check("R1", int'(burst_o), 0, "burst after release");
    check("R1", int'(ramp_o), 0, "ramp after release");

    // R2: cycle length P+1
    phase_tag = "R2";
    run(40);
    @(posedge burst_o); @(negedge clk);
    t_gap = 0;
    do begin @(negedge clk); t_gap++; end while (!(burst_o && !m_burst_prev_low()));
    check("R2", t_gap, 10, "rise-to-rise clocks");

    // R3: brightness changes mid cycle
    phase_tag = "R3"; period_i = 16'd20;
    for (int i = 0; i < 60; i++) begin
      bright_i = 8'($urandom_range(0, 255));
      run($urandom_range(1, 7));
    end

    // R5: inverted slope, random periods
    phase_tag = "R5"; slope_inv_i = 1;
    for (int i = 0; i < 20; i++) begin
      bright_i = 8'($urandom_range(0, 255));
      period_i = 16'($urandom_range(5, 60));
      run(20);
    end
    bright_i = 8'd255; period_i = 16'd15;
    run(40);
    hi_cnt = 0;
    for (int i = 0; i < 32; i++) begin @(negedge clk); hi_cnt += int'(burst_o); end
    check("R5", hi_cnt, 0, "inverted full code gives no burst");

    // R4: zero duty, positive slope
    phase_tag = "R4"; slope_inv_i = 0; bright_i = 8'd0;
    run(40);
    hi_cnt = 0;
    for (int i = 0; i < 32; i++) begin @(negedge clk); hi_cnt += int'(burst_o); end
    check("R4", hi_cnt, 0, "zero duty burst clocks");

    // R9: full-on short period, restart collides with ramp steps
    phase_tag = "R9"; bright_i = 8'd255; period_i = 16'd10;
    run(80);
    check("R9", int'(burst_o), 1, "continuous burst");

    // R8: long burst reaches saturation
    phase_tag = "R8"; period_i = 16'd1000;
    run(1000);
    run(900);
    check("R8", int'(ramp_o), 255, "saturated ramp");

    // R6: external pass-through, bright/slope scrambled
    phase_tag = "R6"; ext_mode_i = 1;
    for (int i = 0; i < 200; i++) begin
      pwm_ext_i   = ~pwm_ext_i;
      bright_i    = 8'($urandom_range(0, 255));
      slope_inv_i = 1'($urandom_range(0, 1));
      run($urandom_range(1, 20));
    end
    pwm_ext_i = 1; run(30);
    check("R6", int'(burst_o), 1, "external high held");

    // mixed random
    for (int i = 0; i < 20; i++) begin
      ext_mode_i  = 1'($urandom_range(0, 1));
      phase_tag   = ext_mode_i ? "R6" : "R4";
      slope_inv_i = 1'($urandom_range(0, 1));
      bright_i    = 8'($urandom_range(0, 255));
      period_i    = 16'($urandom_range(3, 120));
      for (int k = 0; k < 20; k++) begin
        pwm_ext_i = 1'($urandom_range(0, 1));
        run($urandom_range(1, 15));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // true when the burst was already high one clock earlier
  logic burst_prev;
  always @(negedge clk) burst_prev <= burst_o;
  function automatic logic m_burst_prev_low();
    return burst_prev;
  endfunction
endmodule